// File: doc/BRIEF.md
# DSP Subsystem Power-Up Sequencer

This block is a hardware state machine that takes a DSP subsystem from power-off to a running core without software walking the steps. A single-cycle start pulse launches the sequence. The block writes a fixed strap value. It then holds the core in reset and stops it, turns on the crystal clock branch and waits for that branch to report that its clock is running. After that it brings up the power domain: head switch, a settle time, LDO bypass, release of the compiler memory clamp, and the memories taken out of standby and sleep retention.

The memory banks are powered one at a time, from the highest index down to index 0, with a fixed settle count after each bank, to keep inrush current low. The word-line clamp is lifted only once every bank is on. The core reset is released before the core clock is enabled, and the stop bit is cleared last. A one-cycle done pulse marks the end. If the clock branch never reports running within the poll budget, the block stops with a sticky error flag and leaves all three reset bits asserted.

Top module: `dsp_pwrup_seq`

## Requirements
- R1: After reset, strap_o is 0x00, rst_ctl_o is 000, xo_en_o and core_clk_en_o are 0, pwr_ctl_o is 0x0060_0000 (word-line clamp bit 21 and compiler memory clamp bit 22 set), mem_pwr_o is 0, and done_o and err_o are 0. The first write after a start sets strap_o to STRAP_VAL (default 0x20).
- R2: The second write sets all three bits of rst_ctl_o at once (bit 0 stop core, bit 1 core reset, bit 2 bus reset).
- R3: The third write sets xo_en_o. The block then samples clk_off_i once every POLL_CYC cycles, with the first sample POLL_CYC cycles after the write, and continues as soon as a sample reads 0.
- R4: If POLL_MAX samples in a row read 1, err_o is set and stays set until the next start, done_o does not pulse, rst_ctl_o stays 111 and no further output changes. A 0 on the POLL_MAX-th sample still counts as success.
- R5: The power writes come in this order: set bit 24 (head switch); then, at least HS_SETTLE cycles later, set bit 25 (LDO bypass); then clear bit 22; then set bits 18 (L2 data standby-not) and 19 (sleep retention-not) in a single write.
- R6: mem_pwr_o gains one bit per write, from bit BANKS-1 down to bit 0. Bits set earlier stay set, and consecutive bank writes are at least BANK_SETTLE cycles apart.
- R7: Bit 21 of pwr_ctl_o is cleared only after every mem_pwr_o bit is set, at least BANK_SETTLE cycles after the last bank write.
- R8: Next, rst_ctl_o bit 1 is cleared, then core_clk_en_o is set, then rst_ctl_o bit 0 is cleared, with done_o pulsing for one cycle as that last write lands. rst_ctl_o bit 2 stays set.
- R9: A start pulse while a sequence is in progress has no effect.
- R10: A start after a finished or aborted run re-initialises the outputs in its first write (pwr_ctl_o to 0x0060_0000, mem_pwr_o, xo_en_o and core_clk_en_o to 0, strap_o to STRAP_VAL), clears err_o and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| clk_off_i | input | 1 | Crystal clock branch status, 1 while its clock is off |
| strap_o | output | 8 | Access strap value |
| rst_ctl_o | output | 3 | Reset control: bit 0 stop core, bit 1 core reset, bit 2 bus reset |
| xo_en_o | output | 1 | Crystal clock branch enable |
| core_clk_en_o | output | 1 | Core clock mux enable |
| pwr_ctl_o | output | 32 | Power control word, bit positions as in R1 and R5 |
| mem_pwr_o | output | BANKS | Per-bank memory power enable |
| done_o | output | 1 | One-cycle pulse when the core has been started |
| err_o | output | 1 | Sticky flag for a clock-off poll timeout |

## Verification
Two functions can decide in the same cycle: the last allowed clock-off sample and the timeout decision. The bench counts clock edges from the crystal enable write and drops clk_off_i so that it is first seen on exactly the POLL_MAX-th sample. It then expects the full power-up to follow with no error. A second run holds clk_off_i high: err_o must still be low a little before the budget runs out and high just after, with the resets left asserted and no further writes. A start pulse is also injected in the middle of the bank walk. The scoreboard would report any extra or reordered write that it caused.

// File: rtl/dsp_pwrup_pkg.sv
package dsp_pwrup_pkg;

  localparam int PWR_W        = 32;
  localparam int PB_STBY_N    = 18;
  localparam int PB_SLPRET_N  = 19;
  localparam int PB_WL_CLAMP  = 21;
  localparam int PB_MEM_CLAMP = 22;
  localparam int PB_HS_ON     = 24;
  localparam int PB_LDO_BYP   = 25;

  localparam int RB_STOP = 0;
  localparam int RB_CORE = 1;
  localparam int RB_BUS  = 2;

  localparam logic [PWR_W-1:0] PWR_INIT =
    (PWR_W'(1) << PB_WL_CLAMP) | (PWR_W'(1) << PB_MEM_CLAMP);

  typedef enum logic [3:0] {
    ST_IDLE, ST_STRAP, ST_RST, ST_XO, ST_POLL, ST_HS, ST_WAIT, ST_LDO,
    ST_QMC, ST_STBY, ST_BANK, ST_WL, ST_CORE, ST_CLK, ST_GO
  } seq_st_e;

endpackage

// File: rtl/dsp_pwrup_timer.sv
module dsp_pwrup_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [TW-1:0] len_i,
  output logic          fire_o
);
  logic [TW-1:0] cnt_q;
  logic          run_q;
  logic          fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (go_i) begin
        cnt_q <= len_i;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q <= TW'(1)) begin
          run_q  <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - TW'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/dsp_pwrup_poller.sv
module dsp_pwrup_poller #(
  parameter int POLL_CYC = 4,
  parameter int POLL_MAX = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic off_i,
  output logic ok_o,
  output logic tmo_o
);
  localparam int KW = (POLL_CYC < 2) ? 1 : $clog2(POLL_CYC + 1);
  localparam int NW = $clog2(POLL_MAX + 1);

  logic [KW-1:0] tick_q;
  logic [NW-1:0] n_q;
  logic          run_q;
  logic          ok_q;
  logic          tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      n_q    <= '0;
      run_q  <= 1'b0;
      ok_q   <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      tmo_q <= 1'b0;
      if (go_i) begin
        run_q  <= 1'b1;
        tick_q <= KW'(POLL_CYC - 1);
        n_q    <= '0;
      end else if (run_q) begin
        if (tick_q == '0) begin
          if (!off_i) begin
            ok_q  <= 1'b1;
            run_q <= 1'b0;
          end else if (n_q == NW'(POLL_MAX - 1)) begin
            tmo_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            n_q    <= n_q + NW'(1);
            tick_q <= KW'(POLL_CYC - 1);
          end
        end else begin
          tick_q <= tick_q - KW'(1);
        end
      end
    end
  end

  assign ok_o  = ok_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/dsp_pwrup_ctrl.sv
module dsp_pwrup_ctrl
  import dsp_pwrup_pkg::*;
#(
  parameter int          BANKS       = 20,
  parameter int          HS_SETTLE   = 16,
  parameter int          BANK_SETTLE = 24,
  parameter logic [7:0]  STRAP_VAL   = 8'h20,
  parameter int          TW          = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             poll_ok_i,
  input  logic             poll_tmo_i,
  input  logic             tmr_fire_i,
  output logic             poll_go_o,
  output logic             tmr_go_o,
  output logic [TW-1:0]    tmr_len_o,
  output logic [7:0]       strap_o,
  output logic [2:0]       rst_ctl_o,
  output logic             xo_en_o,
  output logic             core_clk_en_o,
  output logic [PWR_W-1:0] pwr_ctl_o,
  output logic [BANKS-1:0] mem_pwr_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int IW = (BANKS < 2) ? 1 : $clog2(BANKS);

  seq_st_e          st_q, ret_q;
  logic [IW-1:0]    idx_q;
  logic [7:0]       strap_q;
  logic [2:0]       rctl_q;
  logic             xo_q, cclk_q, done_q, err_q;
  logic [PWR_W-1:0] pwr_q;
  logic [BANKS-1:0] mem_q;

  assign poll_go_o = (st_q == ST_XO);
  assign tmr_go_o  = (st_q == ST_HS) || (st_q == ST_BANK);
  assign tmr_len_o = (st_q == ST_HS) ? TW'(HS_SETTLE) : TW'(BANK_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ret_q   <= ST_IDLE;
      idx_q   <= '0;
      strap_q <= '0;
      rctl_q  <= '0;
      xo_q    <= 1'b0;
      cclk_q  <= 1'b0;
      pwr_q   <= PWR_INIT;
      mem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= (st_q == ST_GO);
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          err_q <= 1'b0;
          st_q  <= ST_STRAP;
        end
        ST_STRAP: begin
          strap_q <= STRAP_VAL;
          pwr_q   <= PWR_INIT;
          mem_q   <= '0;
          xo_q    <= 1'b0;
          cclk_q  <= 1'b0;
          st_q    <= ST_RST;
        end
        ST_RST: begin
          rctl_q[RB_STOP] <= 1'b1;
          rctl_q[RB_CORE] <= 1'b1;
          rctl_q[RB_BUS]  <= 1'b1;
          st_q            <= ST_XO;
        end
        ST_XO: begin
          xo_q <= 1'b1;
          st_q <= ST_POLL;
        end
        ST_POLL: begin
          if (poll_ok_i) begin
            st_q <= ST_HS;
          end else if (poll_tmo_i) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_HS: begin
          pwr_q[PB_HS_ON] <= 1'b1;
          ret_q           <= ST_LDO;
          st_q            <= ST_WAIT;
        end
        ST_WAIT: if (tmr_fire_i) st_q <= ret_q;
        ST_LDO: begin
          pwr_q[PB_LDO_BYP] <= 1'b1;
          st_q              <= ST_QMC;
        end
        ST_QMC: begin
          pwr_q[PB_MEM_CLAMP] <= 1'b0;
          st_q                <= ST_STBY;
        end
        ST_STBY: begin
          pwr_q[PB_STBY_N]   <= 1'b1;
          pwr_q[PB_SLPRET_N] <= 1'b1;
          idx_q              <= IW'(BANKS - 1);
          st_q               <= ST_BANK;
        end
        ST_BANK: begin
          mem_q[idx_q] <= 1'b1;
          if (idx_q == '0) begin
            ret_q <= ST_WL;
          end else begin
            ret_q <= ST_BANK;
            idx_q <= idx_q - IW'(1);
          end
          st_q <= ST_WAIT;
        end
        ST_WL: begin
          pwr_q[PB_WL_CLAMP] <= 1'b0;
          st_q               <= ST_CORE;
        end
        ST_CORE: begin
          rctl_q[RB_CORE] <= 1'b0;
          st_q            <= ST_CLK;
        end
        ST_CLK: begin
          cclk_q <= 1'b1;
          st_q   <= ST_GO;
        end
        ST_GO: begin
          rctl_q[RB_STOP] <= 1'b0;
          st_q            <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign strap_o       = strap_q;
  assign rst_ctl_o     = rctl_q;
  assign xo_en_o       = xo_q;
  assign core_clk_en_o = cclk_q;
  assign pwr_ctl_o     = pwr_q;
  assign mem_pwr_o     = mem_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
endmodule

// File: rtl/dsp_pwrup_seq.sv
module dsp_pwrup_seq #(
  parameter int         BANKS       = 20,
  parameter int         HS_SETTLE   = 16,
  parameter int         BANK_SETTLE = 24,
  parameter int         POLL_CYC    = 4,
  parameter int         POLL_MAX    = 200,
  parameter logic [7:0] STRAP_VAL   = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             clk_off_i,
  output logic [7:0]       strap_o,
  output logic [2:0]       rst_ctl_o,
  output logic             xo_en_o,
  output logic             core_clk_en_o,
  output logic [31:0]      pwr_ctl_o,
  output logic [BANKS-1:0] mem_pwr_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int MAX_SETTLE = (HS_SETTLE > BANK_SETTLE) ? HS_SETTLE : BANK_SETTLE;
  localparam int TW         = $clog2(MAX_SETTLE + 1);

  logic          poll_go, poll_ok, poll_tmo;
  logic          tmr_go, tmr_fire;
  logic [TW-1:0] tmr_len;

  dsp_pwrup_ctrl #(
    .BANKS(BANKS), .HS_SETTLE(HS_SETTLE), .BANK_SETTLE(BANK_SETTLE),
    .STRAP_VAL(STRAP_VAL), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .poll_ok_i(poll_ok), .poll_tmo_i(poll_tmo), .tmr_fire_i(tmr_fire),
    .poll_go_o(poll_go), .tmr_go_o(tmr_go), .tmr_len_o(tmr_len),
    .strap_o(strap_o), .rst_ctl_o(rst_ctl_o), .xo_en_o(xo_en_o),
    .core_clk_en_o(core_clk_en_o), .pwr_ctl_o(pwr_ctl_o),
    .mem_pwr_o(mem_pwr_o), .done_o(done_o), .err_o(err_o)
  );

  dsp_pwrup_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .go_i(tmr_go), .len_i(tmr_len), .fire_o(tmr_fire)
  );

  dsp_pwrup_poller #(.POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u_poller (
    .clk(clk), .rst(rst), .go_i(poll_go), .off_i(clk_off_i),
    .ok_o(poll_ok), .tmo_o(poll_tmo)
  );
endmodule

// File: rtl/dsp_pwrup_seq_chk.sv
module dsp_pwrup_seq_chk #(
  parameter int BANKS = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       rst_ctl_o,
  input logic             core_clk_en_o,
  input logic [31:0]      pwr_ctl_o,
  input logic [BANKS-1:0] mem_pwr_o,
  input logic             done_o,
  input logic             err_o
);
  AST_LDO_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_ctl_o[25]) |-> pwr_ctl_o[24]);  // R5
  AST_ONE_BANK_STEP: assert property (@(posedge clk) disable iff (rst)
    ($countones(mem_pwr_o) > $countones($past(mem_pwr_o)))
      |-> ($countones(mem_pwr_o ^ $past(mem_pwr_o)) == 1));  // R6
  AST_WL_AFTER_BANKS: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_ctl_o[21]) |-> (&mem_pwr_o));  // R7
  AST_CLK_AFTER_CORE: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en_o) |-> !rst_ctl_o[1]);  // R8
  AST_STOP_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_ctl_o[0]) |-> (core_clk_en_o && (&mem_pwr_o)));  // R8
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rst_ctl_o == 3'b100 && core_clk_en_o));  // R8
  AST_ERR_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (rst_ctl_o == 3'b111 && !pwr_ctl_o[24]));  // R4
endmodule

bind dsp_pwrup_seq dsp_pwrup_seq_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst(rst), .rst_ctl_o(rst_ctl_o), .core_clk_en_o(core_clk_en_o),
  .pwr_ctl_o(pwr_ctl_o), .mem_pwr_o(mem_pwr_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/dsp_pwrup_seq_test.sv
module dsp_pwrup_seq_test;
  localparam int BANKS       = 20;
  localparam int HS_SETTLE   = 16;
  localparam int BANK_SETTLE = 24;
  localparam int POLL_CYC    = 4;
  localparam int POLL_MAX    = 200;
  localparam int SW          = 8 + 3 + 1 + 1 + 32 + BANKS;

  typedef struct {
    logic [SW-1:0] snap;
    int            gap;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic clk_off_i = 1'b1;
  logic [7:0]       strap_o;
  logic [2:0]       rst_ctl_o;
  logic             xo_en_o, core_clk_en_o, done_o, err_o;
  logic [31:0]      pwr_ctl_o;
  logic [BANKS-1:0] mem_pwr_o;

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  item_t         q[$];
  logic [SW-1:0] last_push;
  logic [7:0]    m_strap;
  logic [2:0]    m_rst;
  logic          m_xo, m_clk;
  logic [31:0]   m_pwr;
  logic [BANKS-1:0] m_mem;

  always #4 clk = ~clk;

  dsp_pwrup_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .clk_off_i(clk_off_i),
    .strap_o(strap_o), .rst_ctl_o(rst_ctl_o), .xo_en_o(xo_en_o),
    .core_clk_en_o(core_clk_en_o), .pwr_ctl_o(pwr_ctl_o),
    .mem_pwr_o(mem_pwr_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [SW-1:0] port_snap();
    return {strap_o, rst_ctl_o, xo_en_o, core_clk_en_o, pwr_ctl_o, mem_pwr_o};
  endfunction

  function automatic logic [SW-1:0] model_snap();
    return {m_strap, m_rst, m_xo, m_clk, m_pwr, m_mem};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input int gap);
    item_t it;
    if (model_snap() == last_push) return;
    it.snap = model_snap();
    it.gap  = gap;
    it.tag  = tag;
    q.push_back(it);
    last_push = it.snap;
  endtask

  // driver: expected write sequence of one run
  task automatic queue_run(input bit ok);
    m_strap = 8'h20; m_pwr = 32'h0060_0000; m_mem = '0; m_xo = 1'b0; m_clk = 1'b0;
    push("R10 strap and re-init", 0);
    m_rst = 3'b111;               push("R2 resets asserted", 0);
    m_xo = 1'b1;                  push("R3 crystal enable", 0);
    if (!ok) return;
    m_pwr[24] = 1'b1;             push("R5 head switch", 0);
    m_pwr[25] = 1'b1;             push("R5 LDO bypass after settle", HS_SETTLE);
    m_pwr[22] = 1'b0;             push("R5 memory clamp off", 0);
    m_pwr[18] = 1'b1; m_pwr[19] = 1'b1; push("R5 standby and retention", 0);
    for (int i = BANKS - 1; i >= 0; i--) begin
      m_mem[i] = 1'b1;
      push("R6 bank step", (i == BANKS - 1) ? 0 : BANK_SETTLE);
    end
    m_pwr[21] = 1'b0;             push("R7 word-line clamp off", BANK_SETTLE);
    m_rst[1] = 1'b0;              push("R8 core reset release", 0);
    m_clk = 1'b1;                 push("R8 core clock on", 0);
    m_rst[0] = 1'b0;              push("R8 stop cleared", 0);
  endtask

  // monitor: pops expected writes as outputs change
  initial begin
    logic [SW-1:0] prev;
    int gap_cnt;
    item_t it;
    gap_cnt = 0;
    prev = '0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        gap_cnt++;
        if (done_o) begin
          dones++;
          check(rst_ctl_o == 3'b100 && core_clk_en_o, "R8 done with core started",
                port_snap(), model_snap());
        end
        if (port_snap() != prev) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected write", port_snap(), prev);
          end else begin
            it = q.pop_front();
            check(port_snap() == it.snap, it.tag, port_snap(), it.snap);
            check(gap_cnt >= it.gap, {it.tag, " settle gap"}, SW'(gap_cnt), SW'(it.gap));
          end
          gap_cnt = 0;
          prev = port_snap();
        end
      end else begin
        prev = port_snap();
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_xo_rise();
    wait (xo_en_o == 1'b0);
    wait (xo_en_o == 1'b1);
    @(negedge clk);
  endtask

  task automatic wait_done(input string tag);
    int n;
    int d0;
    d0 = dones;
    n = 0;
    while (dones == d0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (5) @(negedge clk);
    check(dones == d0 + 1, tag, SW'(dones), SW'(d0 + 1));
    check(q.size() == 0, "R8 all writes seen", SW'(q.size()), '0);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_strap = '0; m_rst = '0; m_xo = 1'b0; m_clk = 1'b0; m_pwr = 32'h0060_0000; m_mem = '0;
    last_push = model_snap();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(port_snap() == model_snap() && !done_o && !err_o, "R1 reset state",
          port_snap(), model_snap());
    mon_en = 1'b1;

    // run A: normal power-up, stray start during the bank walk
    queue_run(1'b1);
    pulse_start();
    wait_xo_rise();
    repeat (30) @(negedge clk);
    clk_off_i = 1'b0;
    wait (mem_pwr_o[10] == 1'b1);
    pulse_start();  // R9 must change nothing
    wait_done("R8 done pulse run A");
    check(err_o == 1'b0, "R4 no error run A", SW'(err_o), '0);

    // run B: clock reported running exactly on the last allowed sample
    clk_off_i = 1'b1;
    queue_run(1'b1);
    pulse_start();
    wait_xo_rise();
    repeat (POLL_CYC * POLL_MAX - 1) @(posedge clk);
    @(negedge clk) clk_off_i = 1'b0;
    wait_done("R4 last sample succeeds, R10 rerun");
    check(err_o == 1'b0, "R4 no error on last sample", SW'(err_o), '0);

    // run C: clock never runs
    clk_off_i = 1'b1;
    queue_run(1'b0);
    pulse_start();
    wait_xo_rise();
    repeat (POLL_CYC * POLL_MAX - 10) @(posedge clk);
    @(negedge clk);
    check(err_o == 1'b0, "R4 error not early", SW'(err_o), '0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(err_o == 1'b1, "R4 error after budget", SW'(err_o), SW'(1));
    check(rst_ctl_o == 3'b111, "R4 resets held", SW'(rst_ctl_o), SW'(3'b111));
    repeat (60) @(negedge clk);
    check(q.size() == 0 && err_o, "R4 no writes after abort", SW'(q.size()), '0);

    // run D: restart after abort clears the error
    queue_run(1'b1);
    pulse_start();
    @(negedge clk);
    check(err_o == 1'b0, "R10 error cleared by start", SW'(err_o), '0);
    wait_xo_rise();
    repeat (12) @(negedge clk);
    clk_off_i = 1'b0;
    wait_done("R10 done after abort");
    check(dones == 3, "R4 done count", SW'(dones), SW'(3));

    finish_run();
  end
endmodule